// File: doc/BRIEF.md
# Pseudo-Cause Interrupt Aggregator

This block merges the summary request lines of three interrupt cause banks into one host interrupt. The banks are receive, transmit and miscellaneous. A pseudo-cause register records which banks have requested since the host last looked. Reading that register also clears it, so the host needs no separate acknowledge write.

A mask register lets software gate the host interrupt while it services the banks. Each set mask bit blocks one bank. Writing all ones silences the line completely.

The mask only gates the interrupt line. It does not stop the pseudo-cause register from recording requests, so a masked bank stays visible to a polling host. Both registers sit on a simple 32-bit read/write bus with single-cycle accesses.

Top module: `pseudo_irq_aggregator`

## Requirements
- R1: After reset, the pseudo-cause register reads 0x00000000, the mask register reads 0xFFFFFFFF and `host_irq` is low.
- R2: The pseudo-cause register is at byte address 0x0. Bit 0 is receive, bit 1 is transmit and bit 2 is miscellaneous. A bit is set at any rising edge where the matching `bank_req` bit is high. Bits 31:3 always read as 0.
- R3: A pseudo-cause bit stays set until the register is read, even if its bank request falls before the read.
- R4: A read of address 0x0 returns the register value in the same cycle and clears it at the closing clock edge. A bit whose bank request is high during that read cycle is set again, so it reads 1 on the next read.
- R5: The mask register is at byte address 0x4 and holds all 32 written bits. It reads back exactly what was written. A 1 in bit i blocks bank i from the host interrupt.
- R6: `host_irq` is a register. At each rising edge it takes the OR, over the banks, of (pseudo-cause bit OR bank request) AND NOT mask bit, using the values before that edge.
- R7: Once the mask holds all ones, `host_irq` is low from the next rising edge onward, whatever is pending.
- R8: Writing 0xFFFFFFF8 to the mask enables all three banks. Masking never stops the pseudo-cause register from recording a request.
- R9: A write to address 0x0 changes nothing. Reads of any address other than 0x0 and 0x4 return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bank_req | input | 3 | Summary request of each bank: bit 0 receive, bit 1 transmit, bit 2 miscellaneous |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| host_irq | output | 1 | Registered host interrupt line |

## Verification
The assertions assume that each bus access lasts exactly one cycle with `bus_en` high. They also assume that `bank_req` changes only between clock edges. The bench meets both by driving every input shortly after a rising edge and releasing `bus_en` after one edge. The assertions further assume that a read and a request on the same bank may coincide. The stimulus therefore holds the miscellaneous request high across two back-to-back reads, which reaches the re-set case on purpose.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned PIC_BUS_W  = 32;
  localparam int unsigned PIC_ADDR_W = 4;
  localparam int unsigned PIC_BANKS  = 3;

  typedef enum logic [1:0] {
    BANK_RX   = 2'd0,
    BANK_TX   = 2'd1,
    BANK_MISC = 2'd2
  } bank_id_e;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/pic_cause_reg.sv
module pic_cause_reg #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] cause_o
);
  logic [N-1:0] cause_q;
  logic [N-1:0] cause_d;

  for (genvar b = 0; b < N; b++) begin : g_bit
    always_comb begin
      cause_d[b] = (cause_q[b] & ~clr_i) | set_i[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cause_q[b] <= 1'b0;
      else        cause_q[b] <= cause_d[b];
    end
  end

  assign cause_o = cause_q;

  // R2: every request seen at an edge is recorded
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((cause_q & $past(set_i)) == $past(set_i)));

  // R3: without a clearing read no bit is lost
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

  // R4: after a clearing read only the live requests remain
  a_r4_clear_reload: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cause_q == $past(set_i)));
endmodule

// File: rtl/pic_mask_reg.sv
module pic_mask_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;
  logic [W-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (wr_i) mask_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  // R5: the mask only changes on a write to it
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(mask_q));

  // R5: a write lands in full
  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (mask_q == $past(wdata_i)));
endmodule

// File: rtl/pic_irq_gen.sv
module pic_irq_gen #(
  parameter int unsigned N = 3,
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cause_i,
  input  logic [N-1:0] req_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  localparam int unsigned PAD = W - N;

  logic [W-1:0] active_w;
  logic         irq_d;
  logic         irq_q;

  always_comb begin
    active_w = {{PAD{1'b0}}, cause_i | req_i};
    irq_d    = |(active_w & ~mask_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R7: a fully set mask silences the line at the next edge
  a_r7_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_i) |=> !irq_o);

  // R6: nothing pending and nothing requested gives a quiet line
  a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause_i == '0) && (req_i == '0)) |=> !irq_o);
endmodule

// File: rtl/pseudo_irq_aggregator.sv
module pseudo_irq_aggregator
  import pic_pkg::*;
#(
  parameter int unsigned N_BANKS    = PIC_BANKS,
  parameter int unsigned DATA_W     = PIC_BUS_W,
  parameter int unsigned ADDR_W     = PIC_ADDR_W,
  parameter logic [ADDR_W-1:0] CAUSE_ADDR = 'h0,
  parameter logic [ADDR_W-1:0] MASK_ADDR  = 'h4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_BANKS-1:0] bank_req,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               host_irq
);
  localparam int unsigned PAD = DATA_W - N_BANKS;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // access decode
  acc_kind_e          acc_kind;
  logic               hit_cause;
  logic               hit_mask;
  logic               cause_clr;
  logic               mask_wr;
  logic [N_BANKS-1:0] cause_w;
  logic [DATA_W-1:0]  mask_w;

  always_comb begin
    if (!bus_en)     acc_kind = ACC_IDLE;
    else if (bus_we) acc_kind = ACC_WRITE;
    else             acc_kind = ACC_READ;

    hit_cause = (bus_addr == CAUSE_ADDR);
    hit_mask  = (bus_addr == MASK_ADDR);
    cause_clr = (acc_kind == ACC_READ)  && hit_cause;
    mask_wr   = (acc_kind == ACC_WRITE) && hit_mask;
  end

  pic_cause_reg #(.N(N_BANKS)) u_cause (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .set_i   (bank_req),
    .clr_i   (cause_clr),
    .cause_o (cause_w)
  );

  pic_mask_reg #(.W(DATA_W)) u_mask (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .wr_i    (mask_wr),
    .wdata_i (bus_wdata),
    .mask_o  (mask_w)
  );

  pic_irq_gen #(.N(N_BANKS), .W(DATA_W)) u_irq (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .cause_i (cause_w),
    .req_i   (bank_req),
    .mask_i  (mask_w),
    .irq_o   (host_irq)
  );

  // read data mux
  always_comb begin
    bus_rdata = '0;
    if (acc_kind == ACC_READ) begin
      if (hit_cause)     bus_rdata = {{PAD{1'b0}}, cause_w};
      else if (hit_mask) bus_rdata = mask_w;
    end
  end

  // R2: bits above the banks never show up in a pseudo-cause read
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_sync_q)
    cause_clr |-> (bus_rdata[DATA_W-1:N_BANKS] == '0));

  // R9: unmapped reads return zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_sync_q)
    ((acc_kind == ACC_READ) && !hit_cause && !hit_mask) |-> (bus_rdata == '0));
endmodule

// File: tb/tb_pseudo_irq_aggregator.sv
module tb_pseudo_irq_aggregator;
  logic        clk;
  logic        rst_n;
  logic [2:0]  bank_req;
  logic        bus_en;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        host_irq;

  int checks;
  int errors;
  bit finished;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  pseudo_irq_aggregator dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bank_req  (bank_req),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .host_irq  (host_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // monitor: pops expected read data and compares mid-cycle
  always @(negedge clk) begin
    if (bus_en && !bus_we && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata=%08h expected=%08h", t, bus_rdata, e);
      end
    end
  end

  task automatic bus_read(input logic [3:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk); #1;
    bus_en = 1'b0;
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic set_req(input logic [2:0] v);
    @(posedge clk); #1;
    bank_req = v;
  endtask

  // advance one edge, then compare host_irq mid-cycle
  task automatic check_irq_next(input logic e, input string t);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (host_irq !== e) begin
      errors++;
      $display("FAIL %s: host_irq=%0b expected=%0b", t, host_irq, e);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    checks = 0; errors = 0; finished = 1'b0;
    rst_n = 1'b0; bank_req = '0; bus_en = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    check_irq_next(1'b0, "R1 irq after reset");
    bus_read(4'h0, 32'h0000_0000, "R1 cause after reset");
    bus_read(4'h4, 32'hFFFF_FFFF, "R1 mask after reset");

    // R7 and R8: a fully masked bank is recorded but raises nothing
    set_req(3'b001);
    set_req(3'b000);
    check_irq_next(1'b0, "R7 masked rx keeps line low");
    bus_read(4'h0, 32'h0000_0001, "R8 rx recorded while masked");
    bus_read(4'h0, 32'h0000_0000, "R4 cleared by read");

    // R5 and R8: enable all three banks
    bus_write(4'h4, 32'hFFFF_FFF8);
    bus_read(4'h4, 32'hFFFF_FFF8, "R5 mask readback");

    // R6 and R3: transmit pulse is held after it falls
    set_req(3'b010);
    check_irq_next(1'b1, "R6 tx raises irq");
    set_req(3'b000);
    check_irq_next(1'b1, "R3 irq held after tx falls");
    bus_read(4'h0, 32'h0000_0002, "R3 tx sticky in cause");
    check_irq_next(1'b0, "R6 irq drops after clear");

    // R4: misc held high across reads sets again
    set_req(3'b100);
    bus_read(4'h0, 32'h0000_0004, "R4 misc first read");
    bus_read(4'h0, 32'h0000_0004, "R4 misc sets again");
    bank_req = 3'b000;
    bus_read(4'h0, 32'h0000_0004, "R4 misc last edge captured");
    bus_read(4'h0, 32'h0000_0000, "R4 misc finally cleared");

    // R5: only transmit enabled
    bus_write(4'h4, 32'hFFFF_FFFD);
    set_req(3'b001);
    check_irq_next(1'b0, "R5 rx blocked by mask bit 0");
    set_req(3'b011);
    check_irq_next(1'b1, "R5 tx passes with bit 1 clear");

    // R7: all ones silences the line one edge after the write lands
    bus_write(4'h4, 32'hFFFF_FFFF);
    check_irq_next(1'b0, "R7 all ones masks line");
    set_req(3'b000);
    bus_read(4'h0, 32'h0000_0003, "R8 cause kept while masked");
    bus_read(4'h0, 32'h0000_0000, "R4 cause cleared");

    // R9: unmapped and read-only addresses
    bus_write(4'h8, 32'h0000_0000);
    bus_write(4'h0, 32'hFFFF_FFFF);
    bus_read(4'h8, 32'h0000_0000, "R9 unmapped read zero");
    bus_read(4'hC, 32'h0000_0000, "R9 second unmapped read zero");
    bus_read(4'h0, 32'h0000_0000, "R9 write to cause ignored");
    bus_read(4'h4, 32'hFFFF_FFFF, "R9 mask untouched by stray write");
    check_irq_next(1'b0, "R9 line quiet");

    repeat (3) @(posedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d reads left, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule